// File: doc/BRIEF.md
# PCI Target Address-Phase Command Decoder

This block watches the address phase of a 32-bit PCI target. On the first rising clock edge where FRAME# is low after being high, it captures the bus command from C/BE[3:0]# and the address from AD. It then decides whether this target claims the cycle, and classifies a claimed cycle as configuration, memory or I/O. The extended memory commands are reduced to a basic read or write, so the logic downstream sees only two memory operations. I/O addresses are forced onto a 32-bit word boundary.

During the data phases the block turns the active-low byte enables into per-lane write strobes or read lane selects. Lane bit i stands for AD[8i+7:8i], so bit 0 is the lowest byte. An I/O access whose byte enables are not a contiguous run of lanes, or that enables no lane at all, raises a target-abort request for the data-phase logic. The data-phase logic paces each transfer with TRDY#. This block keeps its decode stable for as many cycles as that takes, and releases it only when FRAME# and IRDY# are both seen deasserted.

The claim is decided by one memory window and one I/O window. Each window has a fixed base and a power-of-two size set by parameters. A configuration cycle is claimed when IDSEL is high and AD[1:0] is 00.

Top module: `pcit_decode`

## Requirements
- R1: Only the command codes 0010, 0011, 0110, 0111, 1010, 1011, 1100, 1110 and 1111 (C/BE# values) can be claimed. A reserved code never claims. While a cycle is not claimed, devsel_n is 1 and space, is_write, addr, wr_lane, rd_lane and target_abort are all 0.
- R2: A claimed cycle reports space as follows: 01 for configuration (1010, 1011), 10 for memory (0110, 0111, 1100, 1110, 1111) and 11 for I/O (0010, 0011). is_write is 1 only for 0011, 0111, 1011 and 1111, so 1100 and 1110 appear as a plain memory read and 1111 as a plain memory write.
- R3: Command and address are captured on the rising edge where FRAME# is sampled low after having been sampled high. The decode outputs change right after that edge. They return to the idle values right after the first edge where FRAME# and IRDY# are both sampled high.
- R4: For a claimed I/O cycle, addr equals the captured AD with bits [1:0] forced to 00. For memory and configuration cycles, addr equals the captured AD unchanged.
- R5: At every data-phase edge of a claimed cycle, the enabled lanes (bit i set when C/BE#[i] is 0, lane i being AD[8i+7:8i]) appear on wr_lane for a write or on rd_lane for a read. The other lane vector stays 0. In the address-phase cycle both vectors are 0.
- R6: In a claimed I/O cycle, a byte-enable pattern with no enabled lane, or with enabled lanes that are not contiguous, sets target_abort after that edge. target_abort then holds until the cycle ends, and both lane vectors stay 0 from that edge on.
- R7: In a memory cycle, any byte-enable pattern, contiguous or not, is passed to the lanes and never raises target_abort.
- R8: A memory command is claimed only when AD[31:MEM_AW] equals MEM_BASE[31:MEM_AW] (default 0x8000_0000 with MEM_AW 20).
- R9: An I/O command is claimed only when AD[31:IO_AW] equals IO_BASE[31:IO_AW] (default 0x0000_1000 with IO_AW 8).
- R10: A configuration command is claimed only when IDSEL is 1 and AD[1:0] is 00 at the capture edge.
- R11: While a cycle is claimed, space, is_write and addr stay unchanged, even when AD and C/BE# change during the data phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_n | input | 1 | FRAME#, active low |
| irdy_n | input | 1 | IRDY#, active low |
| idsel | input | 1 | Configuration select |
| cbe_n | input | 4 | Command in the address phase, byte enables in the data phases (active low) |
| ad | input | 32 | Address/data bus |
| devsel_n | output | 1 | Claim, active low |
| space | output | 2 | 00 none, 01 configuration, 10 memory, 11 I/O |
| is_write | output | 1 | Basic write (1) or read (0) |
| addr | output | 32 | Captured address, word-aligned for I/O |
| wr_lane | output | 4 | Per-lane write strobes |
| rd_lane | output | 4 | Per-lane read selects |
| target_abort | output | 1 | Request to end the cycle with Target Abort |

## Verification
Every result is registered once. The claim, space, direction and address are due right after the capture edge. Each data phase's lane vectors and abort are due right after the edge that samples those byte enables, and the idle values are due right after the edge that sees FRAME# and IRDY# both high. The driver changes inputs and takes samples only at falling edges. For each falling edge that follows one of those rising edges, it queues one expected record of all outputs, computed from the command table, the window bounds and a list of legal I/O lane patterns. The monitor compares that record at the same falling edge. AD is inverted during the data phases, so a decode that followed the bus instead of the captured values would show up.

// File: rtl/pcit_pkg.sv
package pcit_pkg;
  localparam int ADDR_W = 32;
  localparam int LANES  = ADDR_W / 8;

  typedef enum logic [1:0] {
    K_NONE = 2'b00,
    K_CFG  = 2'b01,
    K_MEM  = 2'b10,
    K_IO   = 2'b11
  } space_e;

  typedef struct packed {
    logic   valid;
    space_e space;
    logic   write;
  } cmd_t;
endpackage

// File: rtl/pcit_cmd_classify.sv
module pcit_cmd_classify
  import pcit_pkg::*;
(
  input  logic [3:0] cbe_n,
  output cmd_t       info
);
  always_comb begin
    info.valid = 1'b1;
    info.write = cbe_n[0];
    unique case (cbe_n)
      4'b0010, 4'b0011:                   info.space = K_IO;
      4'b0110, 4'b0111, 4'b1100,
      4'b1110, 4'b1111:                   info.space = K_MEM;
      4'b1010, 4'b1011:                   info.space = K_CFG;
      default: begin
        info.space = K_NONE;
        info.valid = 1'b0;
        info.write = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/pcit_win_match.sv
module pcit_win_match
  import pcit_pkg::*;
#(
  parameter logic [ADDR_W-1:0] BASE   = '0,
  parameter int                SIZE_W = 8,
  parameter bit                ENABLE = 1'b1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  localparam int TOP = ADDR_W - 1;

  generate
    if (ENABLE) begin : g_on
      assign hit = (addr[TOP:SIZE_W] == BASE[TOP:SIZE_W]);
    end else begin : g_off
      assign hit = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/pcit_lane_gen.sv
module pcit_lane_gen
  import pcit_pkg::*;
(
  input  logic [LANES-1:0] cbe_n,
  input  space_e           space,
  input  logic             write,
  input  logic             live,
  output logic [LANES-1:0] wr_lane,
  output logic [LANES-1:0] rd_lane,
  output logic             illegal
);
  logic [LANES-1:0] en;
  logic             run_ok;

  function automatic logic one_run(input logic [LANES-1:0] v);
    logic started, gapped, broken;
    started = 1'b0;
    gapped  = 1'b0;
    broken  = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      if (v[i]) begin
        if (gapped) broken = 1'b1;
        started = 1'b1;
      end else if (started) begin
        gapped = 1'b1;
      end
    end
    return started && !broken;
  endfunction

  always_comb begin
    en      = ~cbe_n;
    run_ok  = one_run(en);
    illegal = live && (space == K_IO) && !run_ok;
    wr_lane = '0;
    rd_lane = '0;
    if (live && !illegal) begin
      if (write) wr_lane = en;
      else       rd_lane = en;
    end
  end
endmodule

// File: rtl/pcit_decode.sv
module pcit_decode
  import pcit_pkg::*;
#(
  parameter logic [31:0] MEM_BASE = 32'h8000_0000,
  parameter int          MEM_AW   = 20,
  parameter bit          MEM_EN   = 1'b1,
  parameter logic [31:0] IO_BASE  = 32'h0000_1000,
  parameter int          IO_AW    = 8,
  parameter bit          IO_EN    = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        frame_n,
  input  logic        irdy_n,
  input  logic        idsel,
  input  logic [3:0]  cbe_n,
  input  logic [31:0] ad,
  output logic        devsel_n,
  output logic [1:0]  space,
  output logic        is_write,
  output logic [31:0] addr,
  output logic [3:0]  wr_lane,
  output logic [3:0]  rd_lane,
  output logic        target_abort
);
  typedef enum logic {ST_IDLE, ST_DATA} st_e;

  st_e              state_q;
  logic             frame_prev_q;
  logic             claim_q;
  space_e           space_q;
  logic             write_q;
  logic             abort_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LANES-1:0] wr_q, rd_q;

  cmd_t             cmd_info;
  logic             mem_hit, io_hit, cfg_ok, claim_d;
  logic [LANES-1:0] wr_d, rd_d;
  logic             lane_bad;
  logic             start, finish;

  pcit_cmd_classify u_cls (
    .cbe_n (cbe_n),
    .info  (cmd_info)
  );

  pcit_win_match #(.BASE(MEM_BASE), .SIZE_W(MEM_AW), .ENABLE(MEM_EN)) u_mem_win (
    .addr (ad),
    .hit  (mem_hit)
  );

  pcit_win_match #(.BASE(IO_BASE), .SIZE_W(IO_AW), .ENABLE(IO_EN)) u_io_win (
    .addr (ad),
    .hit  (io_hit)
  );

  pcit_lane_gen u_lane (
    .cbe_n   (cbe_n),
    .space   (space_q),
    .write   (write_q),
    .live    (claim_q && !abort_q),
    .wr_lane (wr_d),
    .rd_lane (rd_d),
    .illegal (lane_bad)
  );

  assign cfg_ok = idsel && (ad[1:0] == 2'b00);

  always_comb begin
    unique case (cmd_info.space)
      K_CFG:   claim_d = cfg_ok;
      K_MEM:   claim_d = mem_hit;
      K_IO:    claim_d = io_hit;
      default: claim_d = 1'b0;
    endcase
  end

  assign start  = (state_q == ST_IDLE) && frame_prev_q && !frame_n;
  assign finish = (state_q == ST_DATA) && frame_n && irdy_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      frame_prev_q <= 1'b1;
      claim_q      <= 1'b0;
      space_q      <= K_NONE;
      write_q      <= 1'b0;
      abort_q      <= 1'b0;
      addr_q       <= '0;
      wr_q         <= '0;
      rd_q         <= '0;
    end else begin
      frame_prev_q <= frame_n;
      if (start) begin
        state_q <= ST_DATA;
        claim_q <= claim_d;
        space_q <= claim_d ? cmd_info.space : K_NONE;
        write_q <= claim_d && cmd_info.write;
        abort_q <= 1'b0;
        wr_q    <= '0;
        rd_q    <= '0;
        if (!claim_d)                  addr_q <= '0;
        else if (cmd_info.space == K_IO) addr_q <= {ad[ADDR_W-1:2], 2'b00};
        else                           addr_q <= ad;
      end else if (finish) begin
        state_q <= ST_IDLE;
        claim_q <= 1'b0;
        space_q <= K_NONE;
        write_q <= 1'b0;
        abort_q <= 1'b0;
        addr_q  <= '0;
        wr_q    <= '0;
        rd_q    <= '0;
      end else if (state_q == ST_DATA) begin
        wr_q <= wr_d;
        rd_q <= rd_d;
        if (lane_bad) abort_q <= 1'b1;
      end
    end
  end

  assign devsel_n     = !claim_q;
  assign space        = space_q;
  assign is_write     = write_q;
  assign addr         = addr_q;
  assign wr_lane      = wr_q;
  assign rd_lane      = rd_q;
  assign target_abort = abort_q;
endmodule

// File: rtl/pcit_decode_chk.sv
module pcit_decode_chk (
  input logic        clk,
  input logic        rst,
  input logic        frame_n,
  input logic        irdy_n,
  input logic        devsel_n,
  input logic [1:0]  space,
  input logic        is_write,
  input logic [31:0] addr,
  input logic [3:0]  wr_lane,
  input logic [3:0]  rd_lane,
  input logic        target_abort
);
  a_r1_unclaimed_quiet: assert property (@(posedge clk) disable iff (rst)
    devsel_n |-> (space == 2'b00 && !is_write && addr == '0 &&
                  wr_lane == '0 && rd_lane == '0 && !target_abort));

  a_r3_claim_after_frame: assert property (@(posedge clk) disable iff (rst)
    $fell(devsel_n) |-> !$past(frame_n));

  a_r3_end_releases: assert property (@(posedge clk) disable iff (rst)
    (!devsel_n && frame_n && irdy_n) |=> devsel_n);

  a_r4_io_word: assert property (@(posedge clk) disable iff (rst)
    (space == 2'b11) |-> (addr[1:0] == 2'b00));

  a_r5_lane_dir: assert property (@(posedge clk) disable iff (rst)
    ((wr_lane != '0) |-> is_write) and ((rd_lane != '0) |-> !is_write));

  a_r6_abort_io_only: assert property (@(posedge clk) disable iff (rst)
    target_abort |-> (space == 2'b11));

  a_r6_abort_mutes: assert property (@(posedge clk) disable iff (rst)
    target_abort |-> (wr_lane == '0 && rd_lane == '0));

  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    (!devsel_n && !$past(devsel_n)) |-> ($stable(space) && $stable(addr) && $stable(is_write)));
endmodule

bind pcit_decode pcit_decode_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .frame_n      (frame_n),
  .irdy_n       (irdy_n),
  .devsel_n     (devsel_n),
  .space        (space),
  .is_write     (is_write),
  .addr         (addr),
  .wr_lane      (wr_lane),
  .rd_lane      (rd_lane),
  .target_abort (target_abort)
);

// File: tb/test_pcit_decode.sv
module test_pcit_decode;
  localparam logic [31:0] MEM_BASE = 32'h8000_0000;
  localparam int          MEM_AW   = 20;
  localparam logic [31:0] IO_BASE  = 32'h0000_1000;
  localparam int          IO_AW    = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frame_n = 1'b1, irdy_n = 1'b1, idsel = 1'b0;
  logic [3:0]  cbe_n = 4'hF;
  logic [31:0] ad = '0;
  logic        devsel_n, is_write, target_abort;
  logic [1:0]  space;
  logic [31:0] addr;
  logic [3:0]  wr_lane, rd_lane;

  typedef struct {
    string       req;
    logic        dv_n;
    logic [1:0]  sp;
    logic        wr;
    logic [31:0] a;
    logic [3:0]  wl;
    logic [3:0]  rl;
    logic        ab;
  } item_t;

  item_t q[$];
  event  ev_sample;
  int    checks = 0, errors = 0;
  bit    done = 1'b0;

  always #2.5 clk = ~clk;

  pcit_decode #(.MEM_BASE(MEM_BASE), .MEM_AW(MEM_AW), .MEM_EN(1'b1),
                .IO_BASE(IO_BASE), .IO_AW(IO_AW), .IO_EN(1'b1)) i_pcit_decode (
    .clk(clk), .rst(rst), .frame_n(frame_n), .irdy_n(irdy_n), .idsel(idsel),
    .cbe_n(cbe_n), .ad(ad), .devsel_n(devsel_n), .space(space), .is_write(is_write),
    .addr(addr), .wr_lane(wr_lane), .rd_lane(rd_lane), .target_abort(target_abort));

  // monitor: pops one expected record per sample point
  initial begin
    forever begin
      @(ev_sample);
      while (q.size() > 0) begin
        item_t e;
        e = q.pop_front();
        checks++;
        if (devsel_n !== e.dv_n || space !== e.sp || is_write !== e.wr || addr !== e.a ||
            wr_lane !== e.wl || rd_lane !== e.rl || target_abort !== e.ab) begin
          errors++;
          $display("FAIL %s: got dv_n=%b sp=%b wr=%b a=%h wl=%b rl=%b ab=%b, exp dv_n=%b sp=%b wr=%b a=%h wl=%b rl=%b ab=%b",
                   e.req, devsel_n, space, is_write, addr, wr_lane, rd_lane, target_abort,
                   e.dv_n, e.sp, e.wr, e.a, e.wl, e.rl, e.ab);
        end
      end
    end
  end

  function automatic item_t idle_item(string tag);
    item_t it;
    it.req = tag; it.dv_n = 1'b1; it.sp = 2'b00; it.wr = 1'b0;
    it.a = '0; it.wl = '0; it.rl = '0; it.ab = 1'b0;
    return it;
  endfunction

  function automatic bit legal_io(logic [3:0] en);
    case (en)
      4'b0001, 4'b0010, 4'b0100, 4'b1000, 4'b0011, 4'b0110,
      4'b1100, 4'b0111, 4'b1110, 4'b1111: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic push_and_sample(item_t it);
    q.push_back(it);
    -> ev_sample;
  endtask

  // driver: one transaction with one or two data phases
  task automatic txn(input logic [3:0] cmd, input logic [31:0] a, input logic sel,
                     input int nd, input logic [3:0] be1, input logic [3:0] be2,
                     input string tag_a, input string tag_d);
    item_t       it;
    logic [1:0]  sp;
    logic        cl, wr, ab;
    logic [3:0]  en;
    case (cmd)
      4'b0010, 4'b0011: begin sp = 2'b11; cl = (a[31:IO_AW] == IO_BASE[31:IO_AW]); end
      4'b0110, 4'b0111, 4'b1100, 4'b1110, 4'b1111:
                        begin sp = 2'b10; cl = (a[31:MEM_AW] == MEM_BASE[31:MEM_AW]); end
      4'b1010, 4'b1011: begin sp = 2'b01; cl = sel && (a[1:0] == 2'b00); end
      default:          begin sp = 2'b00; cl = 1'b0; end
    endcase
    wr = cl && (cmd == 4'b0011 || cmd == 4'b0111 || cmd == 4'b1011 || cmd == 4'b1111);
    ab = 1'b0;
    // address phase
    frame_n = 1'b0; cbe_n = cmd; ad = a; idsel = sel;
    @(posedge clk); @(negedge clk);
    it = idle_item(tag_a);
    if (cl) begin
      it.dv_n = 1'b0; it.sp = sp; it.wr = wr;
      it.a = (sp == 2'b11) ? {a[31:2], 2'b00} : a;
    end
    push_and_sample(it);
    for (int k = 0; k < nd; k++) begin
      cbe_n = (k == 0) ? be1 : be2;
      irdy_n = 1'b0; ad = ~a; idsel = 1'b0;
      frame_n = (k == nd - 1);
      en = ~cbe_n;
      @(posedge clk); @(negedge clk);
      it.req = tag_d;
      it.wl = '0; it.rl = '0;
      if (cl && !ab) begin
        if (sp == 2'b11 && !legal_io(en)) ab = 1'b1;
        else if (wr) it.wl = en;
        else         it.rl = en;
      end
      it.ab = ab;
      push_and_sample(it);
    end
    // end of cycle
    frame_n = 1'b1; irdy_n = 1'b1; cbe_n = 4'hF; ad = '0;
    @(posedge clk); @(negedge clk);
    push_and_sample(idle_item("R3"));
  endtask

  // watchdog
  initial begin
    for (int c = 0; c < 20000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, got hung, exp completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    push_and_sample(idle_item("R1"));  // reset state

    // R8 memory window, R2 plain read, R5 single lane 0
    txn(4'b0110, 32'h8000_1234, 1'b0, 1, 4'b1110, 4'hF, "R8", "R5");
    // R8 top word of window, R5 all lanes written
    txn(4'b0111, 32'h800F_FFFC, 1'b0, 1, 4'b0000, 4'hF, "R8", "R5");
    // R2 read multiple folds to read
    txn(4'b1100, 32'h8000_0040, 1'b0, 1, 4'b0011, 4'hF, "R2", "R5");
    // R2 read line folds to read
    txn(4'b1110, 32'h8000_0080, 1'b0, 1, 4'b1001, 4'hF, "R2", "R7");
    // R2 write-and-invalidate folds to write, R7 non-contiguous mem, R11 hold
    txn(4'b1111, 32'h8008_0000, 1'b0, 2, 4'b0000, 4'b1010, "R11", "R7");
    // R8 just above the window
    txn(4'b0110, 32'h8010_0000, 1'b0, 1, 4'b0000, 4'hF, "R8", "R8");
    // R8 just below the window
    txn(4'b0111, 32'h7FFF_FFFC, 1'b0, 1, 4'b0000, 4'hF, "R8", "R8");
    // R4 I/O address aligned, R9 window, R5 lanes 0-1
    txn(4'b0011, 32'h0000_10FF, 1'b0, 1, 4'b1100, 4'hF, "R4", "R5");
    // R6 non-contiguous I/O read aborts
    txn(4'b0010, 32'h0000_1002, 1'b0, 1, 4'b1010, 4'hF, "R4", "R6");
    // R6 no lane enabled on I/O aborts
    txn(4'b0010, 32'h0000_1010, 1'b0, 1, 4'b1111, 4'hF, "R9", "R6");
    // R6 abort in second phase, sticky state checked at end
    txn(4'b0011, 32'h0000_1020, 1'b0, 2, 4'b1001, 4'b0110, "R9", "R6");
    // R9 outside I/O window
    txn(4'b0011, 32'h0000_1100, 1'b0, 1, 4'b0000, 4'hF, "R9", "R9");
    // R10 configuration read claimed
    txn(4'b1010, 32'h0000_0010, 1'b1, 1, 4'b0000, 4'hF, "R10", "R5");
    // R10 configuration write without IDSEL
    txn(4'b1011, 32'h0000_0010, 1'b0, 1, 4'b0000, 4'hF, "R10", "R10");
    // R10 configuration with AD[1:0] = 01
    txn(4'b1010, 32'h0000_0011, 1'b1, 1, 4'b0000, 4'hF, "R10", "R10");
    // R10 configuration write claimed
    txn(4'b1011, 32'h0000_0104, 1'b1, 1, 4'b1000, 4'hF, "R2", "R5");
    // R1 reserved codes inside the memory window
    txn(4'b0000, 32'h8000_0000, 1'b0, 1, 4'b0000, 4'hF, "R1", "R1");
    txn(4'b0100, 32'h8000_0000, 1'b0, 1, 4'b0000, 4'hF, "R1", "R1");
    txn(4'b1101, 32'h8000_0000, 1'b1, 1, 4'b0000, 4'hF, "R1", "R1");
    txn(4'b1000, 32'h0000_1000, 1'b0, 1, 4'b0000, 4'hF, "R1", "R1");

    @(negedge clk);
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule